// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block lays a 32x32 pointer image over a stream of palette-indexed pixels. Each pixel arrives with its screen coordinate and an 8-bit colour index. The block either passes that index through unchanged or replaces it with one of two overlay colour selects. The image is held as two bit planes of 32 words each, one word per cursor row: a visibility mask and a colour bit. The leftmost cursor pixel is the most significant bit of its row word.

Software reaches the block through a 32-bit register port with byte offsets. One packed word gives the cursor's top-left corner. Two windows of 32 row words hold the planes. A general-purpose word stores whatever is written to it, and reads of that word always show one fixed status bit set. Right after reset the cursor sits far outside any visible area, so nothing is overlaid until software moves it.

The output carries one register stage and a flag that tells a main-palette index apart from an overlay select. When the flag is set, the index field holds 2 or 3. The palette downstream maps these to its extra entries 258 and 259.

Top module: `hw_cursor_overlay`

## Requirements
- R1: After reset the cursor corner is X = Y = 0xF000, every pixel passes through with out_ovl = 0, and the general word at offset 0x818 reads 0x0200_0000.
- R2: A read at offset 0x818 returns the last value written there OR 0x0200_0000. A read at any other offset returns 0, including the position and row-word offsets.
- R3: A write to offset 0x8FC sets the cursor X from data bits 31:16 and the cursor Y from bits 15:0.
- R4: A write at 0x900 + 4*r loads mask row r, and a write at 0x980 + 4*r loads colour row r (r = 0..31). Bit 31 of a row word is cursor column 0, the leftmost, and bit 0 is column 31.
- R5: For a pixel inside the cursor, mask 1 with colour 1 gives out_ovl = 1 and out_idx = 3 (overlay entry 259). Mask 1 with colour 0 gives out_ovl = 1 and out_idx = 2 (entry 258). Mask 0 passes the input index with out_ovl = 0.
- R6: Only rows with cur_y <= pix_y < cur_y + 32 can be overlaid. Pixels above or below that band pass through.
- R7: Only columns with cur_x <= pix_x < cur_x + 32 and pix_x < ACTIVE_W can be overlaid. A cursor whose X is not below ACTIVE_W draws nothing, so the cursor is clipped at the right screen edge.
- R8: out_valid and the output pixel follow pix_valid and the input pixel exactly one clock later. When pix_valid is 0, out_ovl and out_idx are 0 in the next cycle.
- R9: Writes to offsets outside the position word, the two row windows and the general word change neither the pixel output nor any read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pix_valid | input | 1 | Input pixel present |
| pix_x | input | 16 | Screen column of input pixel |
| pix_y | input | 16 | Screen row of input pixel |
| pix_idx | input | 8 | Palette index of input pixel |
| out_valid | output | 1 | Output pixel present |
| out_idx | output | 8 | Main index, or overlay select 2/3 |
| out_ovl | output | 1 | 1 when out_idx is an overlay select |

## Verification
The properties assume that the cursor position seen by a pixel is the one held before that pixel's clock edge, so a position write and a pixel in the same cycle are judged against the old corner. They also assume the stream never presents unknown coordinates while pix_valid is high. The bench keeps register writes and pixel cycles apart. It drives only word-aligned offsets and places every coordinate it sends in a known position relative to the cursor band and the active width. Its expected pixels come from its own copy of the position and plane words, updated from the writes it issues.

// File: rtl/cursor_pkg.sv
// cursor_pkg: shared constants for the cursor overlay.
// Assumes byte offsets on a 12-bit register port and 32-bit row words.
package cursor_pkg;
    localparam int CUR_DIM  = 32;              // cursor rows and columns
    localparam int ROW_AW   = $clog2(CUR_DIM); // row/column index width
    localparam int REG_AW   = 12;
    localparam int REG_DW   = 32;
    localparam int COORD_W  = 16;
    localparam int IDX_W    = 8;

    localparam logic [REG_AW-1:0] OFS_GENERAL = 12'h818;
    localparam logic [REG_AW-1:0] OFS_CORNER  = 12'h8FC;
    // Upper address bits that select each 32-word row window
    localparam logic [4:0] WIN_MASK   = 5'h12; // 0x900..0x97C
    localparam logic [4:0] WIN_COLOUR = 5'h13; // 0x980..0x9FC
    localparam logic [REG_DW-1:0] STATUS_FORCE = 32'h0200_0000;

    // Overlay selects, offset from the first extra palette entry (256)
    localparam logic [IDX_W-1:0] OVL_SEL_CLEAR = 8'd2; // entry 258
    localparam logic [IDX_W-1:0] OVL_SEL_SET   = 8'd3; // entry 259
endpackage

// File: rtl/cursor_regs.sv
// cursor_regs: register file for the cursor corner, both bit planes and
// the general word. Writes are decoded on the full byte offset (row
// windows ignore the two low bits). Reads are combinational and only the
// general word reads back; it always shows the forced status bit.
module cursor_regs
    import cursor_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [REG_AW-1:0]   addr,
    input  logic [REG_DW-1:0]   wdata,
    output logic [REG_DW-1:0]   rdata,
    output logic [COORD_W-1:0]  cur_x,
    output logic [COORD_W-1:0]  cur_y,
    output logic [CUR_DIM-1:0]  mask_rows   [CUR_DIM],
    output logic [CUR_DIM-1:0]  colour_rows [CUR_DIM]
);
    localparam logic [COORD_W-1:0] PARK = 16'hF000;

    logic [REG_DW-1:0] general_q;
    logic [ROW_AW-1:0] wr_row;
    logic              hit_mask_win;
    logic              hit_colour_win;

    // Decode which window a write targets
    always_comb begin
        wr_row         = addr[ROW_AW+1:2];
        hit_mask_win   = (addr[REG_AW-1:7] == WIN_MASK);
        hit_colour_win = (addr[REG_AW-1:7] == WIN_COLOUR);
    end

    // Corner register: packed X in the high half, Y in the low half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= PARK;
            cur_y <= PARK;
        end else if (we && addr == OFS_CORNER) begin
            cur_x <= wdata[31:16];
            cur_y <= wdata[15:0];
        end
    end

    // General-purpose word
    always_ff @(posedge clk) begin
        if (!rst_n)
            general_q <= '0;
        else if (we && addr == OFS_GENERAL)
            general_q <= wdata;
    end

    // One mask word and one colour word per cursor row
    for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_rows[r] <= '0;
            else if (we && hit_mask_win && wr_row == ROW_AW'(r))
                mask_rows[r] <= wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                colour_rows[r] <= '0;
            else if (we && hit_colour_win && wr_row == ROW_AW'(r))
                colour_rows[r] <= wdata;
        end
    end

    // Read mux: only the general word is visible
    always_comb begin
        rdata = (addr == OFS_GENERAL) ? (general_q | STATUS_FORCE) : '0;
    end
endmodule

// File: rtl/cursor_hit.sv
// cursor_hit: decides whether a pixel coordinate falls inside the cursor
// square and is not clipped by the active width, then fetches the mask
// and colour bits for it. Purely combinational. Coordinates are widened
// by one bit so that the band end cannot wrap.
module cursor_hit
    import cursor_pkg::*;
#(
    parameter int ACTIVE_W = 1024
)(
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic [COORD_W-1:0]  cur_x,
    input  logic [COORD_W-1:0]  cur_y,
    input  logic [CUR_DIM-1:0]  mask_rows   [CUR_DIM],
    input  logic [CUR_DIM-1:0]  colour_rows [CUR_DIM],
    output logic                show,
    output logic                colour_bit
);
    localparam int EW = COORD_W + 1;
    localparam logic [EW-1:0] W_EXT   = EW'(ACTIVE_W);
    localparam logic [EW-1:0] DIM_EXT = EW'(CUR_DIM);

    logic [EW-1:0]     px, py, cx, cy;
    logic              in_band, in_span, on_screen;
    logic [ROW_AW-1:0] row, col;
    logic [CUR_DIM-1:0] mrow, crow;

    // Window test in widened arithmetic
    always_comb begin
        px = {1'b0, pix_x};
        py = {1'b0, pix_y};
        cx = {1'b0, cur_x};
        cy = {1'b0, cur_y};
        in_band   = (py >= cy) && (py < cy + DIM_EXT);
        in_span   = (px >= cx) && (px < cx + DIM_EXT);
        on_screen = (px < W_EXT) && (cx < W_EXT);
    end

    // Row and column inside the cursor; column 0 is bit 31
    always_comb begin
        row  = ROW_AW'(pix_y - cur_y);
        col  = ROW_AW'(pix_x - cur_x);
        mrow = mask_rows[row];
        crow = colour_rows[row];
        show       = in_band && in_span && on_screen && mrow[~col];
        colour_bit = crow[~col];
    end
endmodule

// File: rtl/cursor_mix.sv
// cursor_mix: output register stage. Replaces the main index by an
// overlay select when the cursor shows, and clears the pixel fields
// when no pixel is present.
module cursor_mix
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [IDX_W-1:0]  pix_idx,
    input  logic              show,
    input  logic              colour_bit,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_ovl
);
    // Register the selected index and its kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_ovl   <= 1'b0;
        end else begin
            out_valid <= pix_valid;
            if (!pix_valid) begin
                out_idx <= '0;
                out_ovl <= 1'b0;
            end else if (show) begin
                out_idx <= colour_bit ? OVL_SEL_SET : OVL_SEL_CLEAR;
                out_ovl <= 1'b1;
            end else begin
                out_idx <= pix_idx;
                out_ovl <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hw_cursor_overlay.sv
// hw_cursor_overlay: top of the two-plane cursor overlay. Wires the
// register file, the hit test and the output stage. Assumes one pixel
// per clock at most and word-aligned register offsets.
module hw_cursor_overlay
    import cursor_pkg::*;
#(
    parameter int ACTIVE_W = 1024
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic                pix_valid,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic                out_valid,
    output logic [IDX_W-1:0]    out_idx,
    output logic                out_ovl
);
    logic [COORD_W-1:0] cur_x, cur_y;
    logic [CUR_DIM-1:0] mask_rows   [CUR_DIM];
    logic [CUR_DIM-1:0] colour_rows [CUR_DIM];
    logic               show, colour_bit;

    cursor_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .cur_x       (cur_x),
        .cur_y       (cur_y),
        .mask_rows   (mask_rows),
        .colour_rows (colour_rows)
    );

    cursor_hit #(.ACTIVE_W(ACTIVE_W)) u_hit (
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .cur_x       (cur_x),
        .cur_y       (cur_y),
        .mask_rows   (mask_rows),
        .colour_rows (colour_rows),
        .show        (show),
        .colour_bit  (colour_bit)
    );

    cursor_mix u_mix (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .pix_idx     (pix_idx),
        .show        (show),
        .colour_bit  (colour_bit),
        .out_valid   (out_valid),
        .out_idx     (out_idx),
        .out_ovl     (out_ovl)
    );
endmodule

// File: rtl/hw_cursor_overlay_chk.sv
// hw_cursor_overlay_chk: temporal checks on the overlay's ports and its
// registered cursor corner. Bound into every instance of the top.
module hw_cursor_overlay_chk
    import cursor_pkg::*;
#(
    parameter int ACTIVE_W = 1024
)(
    input logic               clk,
    input logic               rst_n,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [REG_DW-1:0]  reg_rdata,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic [COORD_W-1:0] cur_y,
    input logic               out_valid,
    input logic [IDX_W-1:0]   out_idx,
    input logic               out_ovl
);
    localparam logic [COORD_W:0] W_EXT = (COORD_W+1)'(ACTIVE_W);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!out_valid && !out_ovl && out_idx == '0));
    // R5
    ovl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovl |-> (out_idx == OVL_SEL_SET || out_idx == OVL_SEL_CLEAR));
    // R6
    above_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_y < cur_y) |=> !out_ovl);
    // R7
    clip_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && {1'b0, pix_x} >= W_EXT) |=> !out_ovl);
    // R2
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_GENERAL) |-> (reg_rdata == '0));
    // R2
    status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_GENERAL) |-> reg_rdata[25]);
endmodule

bind hw_cursor_overlay hw_cursor_overlay_chk #(.ACTIVE_W(ACTIVE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .cur_y     (cur_y),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_ovl   (out_ovl)
);

// File: tb/sim_hw_cursor_overlay.sv
// sim_hw_cursor_overlay: directed bench, one task per scenario. Expected
// pixels come from a bench-side model of the written registers.
module sim_hw_cursor_overlay;
    localparam int W = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [7:0]  pix_idx = '0;
    logic        out_valid, out_ovl;
    logic [7:0]  out_idx;

    int total = 0, bad = 0;
    bit done = 0;

    int m_cx, m_cy;
    logic [31:0] m_mask [32];
    logic [31:0] m_col  [32];

    always #2.5 clk = ~clk;

    hw_cursor_overlay #(.ACTIVE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_idx(pix_idx),
        .out_valid(out_valid), .out_idx(out_idx), .out_ovl(out_ovl));

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic reg_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 12'h8FC) begin m_cx = int'(d[31:16]); m_cy = int'(d[15:0]); end
        else if (a >= 12'h900 && a <= 12'h97C) m_mask[(a - 12'h900) >> 2] = d;
        else if (a >= 12'h980 && a <= 12'h9FC) m_col[(a - 12'h980) >> 2] = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0;
    endtask

    task automatic reg_read_chk(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
        reg_addr = '0;
    endtask

    // Expected {ovl, idx} from the requirements
    function automatic logic [8:0] expect_px(int x, int y, logic [7:0] idx);
        int r, c;
        if (y >= m_cy && y < m_cy + 32 && x >= m_cx && x < m_cx + 32 &&
            x < W && m_cx < W) begin
            r = y - m_cy; c = x - m_cx;
            if (m_mask[r][31-c]) return {1'b1, m_col[r][31-c] ? 8'd3 : 8'd2};
        end
        return {1'b0, idx};
    endfunction

    task automatic px_chk(string req, int x, int y, logic [7:0] idx);
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_idx = idx;
        @(posedge clk); #1;
        check(req, {23'd0, out_valid, out_ovl, out_idx}, {23'd0, 1'b1, expect_px(x, y, idx)});
        pix_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        reg_read_chk("R1 general", 12'h818, 32'h0200_0000);
        px_chk("R1 origin", 0, 0, 8'h55);
        px_chk("R1 corner", 1023, 767, 8'hA7);
        px_chk("R1 parked", 16'hF000, 16'hF000, 8'h11);
    endtask

    task automatic t_general_reads;
        reg_write(12'h818, 32'h0000_00A5);
        reg_read_chk("R2 or bit", 12'h818, 32'h0200_00A5);
        reg_write(12'h818, 32'hFFFF_FFFF);
        reg_read_chk("R2 all ones", 12'h818, 32'hFFFF_FFFF);
        reg_read_chk("R2 corner reads 0", 12'h8FC, 32'h0);
        reg_read_chk("R2 mask reads 0", 12'h900, 32'h0);
        reg_read_chk("R2 low reads 0", 12'h000, 32'h0);
    endtask

    task automatic t_position_rows;
        reg_write(12'h8FC, {16'd100, 16'd50});
        reg_write(12'h900, 32'h8000_0001);
        reg_write(12'h980, 32'h8000_0000);
        px_chk("R3 R4 left col", 100, 50, 8'h20);
        px_chk("R4 right col", 131, 50, 8'h21);
        px_chk("R4 empty col", 101, 50, 8'h22);
        px_chk("R3 left of cursor", 99, 50, 8'h23);
        px_chk("R3 right of cursor", 132, 50, 8'h24);
    endtask

    task automatic t_colours;
        reg_write(12'h97C, 32'hFFFF_FFFF);
        reg_write(12'h9FC, 32'h0000_FFFF);
        reg_write(12'h984, 32'hFFFF_FFFF);
        px_chk("R5 set colour", 116, 81, 8'h30);
        px_chk("R5 clear colour", 115, 81, 8'h31);
        px_chk("R5 mask zero", 105, 51, 8'h32);
    endtask

    task automatic t_vertical;
        px_chk("R6 below band", 116, 82, 8'h40);
        px_chk("R6 above band", 100, 49, 8'h41);
        px_chk("R6 top row", 100, 50, 8'h42);
    endtask

    task automatic t_clip;
        reg_write(12'h8FC, {16'd1010, 16'd0});
        reg_write(12'h900, 32'hFFFF_FFFF);
        reg_write(12'h980, 32'h0);
        px_chk("R7 last visible col", 1023, 0, 8'h50);
        px_chk("R7 past edge", 1024, 0, 8'h51);
        px_chk("R7 first col", 1010, 0, 8'h52);
        reg_write(12'h8FC, {16'd1024, 16'd0});
        px_chk("R7 corner off width", 1024, 0, 8'h53);
        px_chk("R7 corner off width low", 1023, 0, 8'h54);
    endtask

    task automatic t_latency;
        reg_write(12'h8FC, {16'd0, 16'd0});
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 16'd0; pix_y = 16'd0; pix_idx = 8'h61;
        @(negedge clk);
        check("R8 stage 1", {23'd0, out_valid, out_ovl, out_idx}, {23'd0, 1'b1, expect_px(0, 0, 8'h61)});
        pix_x = 16'd40; pix_idx = 8'h62;
        @(negedge clk);
        check("R8 stage 2", {23'd0, out_valid, out_ovl, out_idx}, {23'd0, 1'b1, expect_px(40, 0, 8'h62)});
        pix_valid = 1'b0;
        @(negedge clk);
        check("R8 idle", {23'd0, out_valid, out_ovl, out_idx}, 32'd0);
    endtask

    task automatic t_ignored;
        reg_write(12'h818, 32'h0000_1234);
        reg_write(12'hA00, 32'hFFFF_FFFF);
        reg_write(12'h8F8, 32'h0000_0000);
        reg_write(12'h81C, 32'hDEAD_BEEF);
        reg_read_chk("R9 general kept", 12'h818, 32'h0200_1234);
        px_chk("R9 cursor kept hit", 0, 0, 8'h70);
        px_chk("R9 cursor kept miss", 33, 0, 8'h71);
    endtask

    initial begin
        #100000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_cx = 16'hF000; m_cy = 16'hF000;
        for (int i = 0; i < 32; i++) begin m_mask[i] = '0; m_col[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_general_reads;
        t_position_rows;
        t_colours;
        t_vertical;
        t_clip;
        t_latency;
        t_ignored;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule